// File: doc/BRIEF.md
# Power-register access sequencer

This block sits on the host side of a command mailbox and turns one request for access to power-controller registers into a complete mailbox transaction. A request names an operation (write, read, or read-modify-write), an item count, a list of 16-bit register addresses and a set of data bytes. The sequencer packs the addresses and data into the mailbox write buffer and writes the command word. It then polls the mailbox status until busy drops or a bounded number of tries runs out. For reads it fetches the response bytes.

It is a bus master on a simple valid/ready register port toward the mailbox. The mailbox is outside this block. A requester holds `req_valid` with its fields until `req_ready` accepts the request. The requester then waits for the one-cycle `done` pulse, which carries a result code. For reads, the returned bytes wait on `rd_data`.

Top module: `pwr_reg_seq`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle, and the bus is then quiet. A request is taken on a cycle with `req_valid` and `req_ready` both high. Every accepted request ends with exactly one single-cycle `done` pulse, after which `req_ready` returns. Result codes on `result` are 0 success, 1 rejected, 2 timeout, 3 I/O error.
- R2: A request whose count is 0, whose count is above MAX_ITEMS (default 5), or whose operation code is 3 is rejected. In that case `done` rises in the cycle after acceptance with result 1, and no bus transfer takes place.
- R3: Buffer layout for write and read: item i's address goes at buffer byte 2i (low byte) and byte 2i+1 (high byte). For a write, data byte i follows at byte 2*count+i. For read-modify-write, the item 0 address fills bytes 0 and 1, `req_data` byte 0 (the new bit values) fills byte 2, and `req_data` byte 1 (the mask, where 1 means update that bit) fills byte 3. Bytes past the size inside the last word are 0.
- R4: The buffer is written as ceil(size/4) 32-bit words, in ascending order at offsets 0x80, 0x84 and so on. Buffer byte 4k sits in bits 7:0 of word k. All buffer words are written before the command word.
- R5: The command word is written to offset 0x00. Bits 7:0 hold 0xFF. Bits 15:12 hold the sub-command: 0 for write (operation 0), 1 for read (operation 1), 2 for read-modify-write (operation 2). Bits 23:16 hold the size: 3*count for a write, 2*count for a read, 4 for read-modify-write. All other bits, including the completion-interrupt bit 8, are 0.
- R6: After the command, status is read at offset 0x04. Bit 0 is busy and bit 1 is error. The first status read that shows busy clear ends the polling, and with error clear the result is 0.
- R7: If error is set when busy clears, the result is 3 and the response buffer is not read.
- R8: If busy is still set on the POLL_TRIES-th status read, the result is 2. Exactly POLL_TRIES status reads are made, with at least POLL_GAP cycles between two of them.
- R9: After a successful read, ceil(count/4) words are read from offsets 0x90, 0x94 and so on. `rd_data` byte i (bits 8i+7:8i) then equals response byte i, for each i below the count.
- R10: While `bus_valid` is high and `bus_ready` is low, the address, direction and write data stay unchanged until the transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken this cycle if offered |
| req_op | input | 2 | 0 write, 1 read, 2 read-modify-write, 3 invalid |
| req_count | input | 4 | Item count |
| req_addr | input | 80 | Item i register address in bits 16i+15:16i |
| req_data | input | 40 | Item i data byte in bits 8i+7:8i (for read-modify-write, byte 0 is the value and byte 1 is the mask) |
| bus_valid | output | 1 | Mailbox transfer requested |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Mailbox byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Transfer accepted this cycle; read data valid |
| bus_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Result code, valid with done |
| rd_data | output | 40 | Bytes returned by a read |

## Verification
The hardest case to reach is the timeout path: the mailbox has to stay busy through every allowed poll, and the spacing between polls must be measured. The bench's mailbox model keeps busy asserted for far longer than the try limit, and the sequencer is built with a small try count and gap. That lets the bench count the status reads and time-stamp each one. Stalled transfers come from a ready signal that toggles every cycle during one full-size write. Buffer contents, word order and command placement are checked against bytes the bench computes itself.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      OP_WR  = 2'd0,
      OP_RD  = 2'd1,
      OP_RMW = 2'd2,
      OP_BAD = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_REJECT  = 2'd1,
      RES_TIMEOUT = 2'd2,
      RES_IOERR   = 2'd3
   } res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WBUF,
      ST_CMD,
      ST_STAT,
      ST_GAP,
      ST_RBUF,
      ST_DONE
   } state_e;

   localparam logic [7:0] CMD_CODE = 8'hFF;
   localparam int BUSY_BIT = 0;
   localparam int ERR_BIT  = 1;

endpackage

// File: rtl/pwr_seq_pack.sv
module pwr_seq_pack
   import pwr_seq_pkg::*;
#(
   parameter int MAX_ITEMS = 5,
   parameter int BUF_BYTES = 16,
   parameter int CNT_W     = 4
) (
   input  op_e                      op,
   input  logic [CNT_W-1:0]         count,
   input  logic [MAX_ITEMS*16-1:0]  addr,
   input  logic [MAX_ITEMS*8-1:0]   data,
   output logic [BUF_BYTES*8-1:0]   buf_bytes,
   output logic [7:0]               size,
   output logic                     legal
);

   always_comb begin
      int cnt;
      cnt       = int'(count);
      buf_bytes = '0;
      size      = 8'd0;
      legal     = (cnt != 0) && (cnt <= MAX_ITEMS) && (op != OP_BAD);
      if (op == OP_RMW) begin
         buf_bytes[15:0]  = addr[15:0];
         buf_bytes[23:16] = data[7:0];
         buf_bytes[31:24] = data[15:8];
         size             = 8'd4;
      end else begin
         for (int i = 0; i < MAX_ITEMS; i++) begin
            if (i < cnt) buf_bytes[i*16 +: 16] = addr[i*16 +: 16];
         end
         if (op == OP_WR) begin
            for (int i = 0; i < MAX_ITEMS; i++) begin
               for (int j = 0; j < BUF_BYTES; j++) begin
                  if (i < cnt && j == 2*cnt + i) buf_bytes[j*8 +: 8] = data[i*8 +: 8];
               end
            end
            size = 8'(3*cnt);
         end else begin
            size = 8'(2*cnt);
         end
      end
   end

endmodule

// File: rtl/pwr_seq_poll.sv
module pwr_seq_poll #(
   parameter int POLL_TRIES = 100000,
   parameter int POLL_GAP   = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   output logic last_try,
   output logic gap_done
);

   localparam int TRY_W = $clog2(POLL_TRIES + 1);
   localparam int GAP_W = $clog2(POLL_GAP + 1) > 0 ? $clog2(POLL_GAP + 1) : 1;

   logic [TRY_W-1:0] tries_q;
   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tries_q <= '0;
         gap_q   <= '0;
      end else begin
         if (load)      tries_q <= TRY_W'(POLL_TRIES);
         else if (step) tries_q <= tries_q - TRY_W'(1);
         if (step)             gap_q <= GAP_W'(POLL_GAP);
         else if (gap_q != '0) gap_q <= gap_q - GAP_W'(1);
      end
   end

   assign last_try = (tries_q <= TRY_W'(1));
   assign gap_done = (gap_q == '0);

endmodule

// File: rtl/pwr_seq_rdcap.sv
module pwr_seq_rdcap #(
   parameter int MAX_ITEMS = 5,
   parameter int IDX_W     = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   cap_en,
   input  logic [IDX_W-1:0]       idx,
   input  logic [31:0]            word,
   output logic [MAX_ITEMS*8-1:0] rd_data
);

   for (genvar k = 0; k < MAX_ITEMS; k++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    rd_data[k*8 +: 8] <= 8'h00;
         else if (clear)                                rd_data[k*8 +: 8] <= 8'h00;
         else if (cap_en && idx == IDX_W'(k/4))         rd_data[k*8 +: 8] <= word[(k%4)*8 +: 8];
      end
   end

endmodule

// File: rtl/pwr_reg_seq.sv
module pwr_reg_seq
   import pwr_seq_pkg::*;
#(
   parameter int MAX_ITEMS  = 5,
   parameter int POLL_TRIES = 100000,
   parameter int POLL_GAP   = 100,
   parameter int ADDR_W     = 8,
   parameter int CMD_OFS    = 'h00,
   parameter int STAT_OFS   = 'h04,
   parameter int WBUF_OFS   = 'h80,
   parameter int RBUF_OFS   = 'h90,
   localparam int CNT_W     = $clog2(MAX_ITEMS + 1) + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [1:0]             req_op,
   input  logic [CNT_W-1:0]       req_count,
   input  logic [MAX_ITEMS*16-1:0] req_addr,
   input  logic [MAX_ITEMS*8-1:0] req_data,
   output logic                   bus_valid,
   output logic                   bus_write,
   output logic [ADDR_W-1:0]      bus_addr,
   output logic [31:0]            bus_wdata,
   input  logic                   bus_ready,
   input  logic [31:0]            bus_rdata,
   output logic                   done,
   output logic [1:0]             result,
   output logic [MAX_ITEMS*8-1:0] rd_data
);

   localparam int BUF_BYTES = ((3*MAX_ITEMS + 3) / 4) * 4;
   localparam int BUF_WORDS = BUF_BYTES / 4;
   localparam int RD_WORDS  = (MAX_ITEMS + 3) / 4;
   localparam int IDX_W     = $clog2(BUF_WORDS);

   if (MAX_ITEMS < 2 || 3*MAX_ITEMS > 255) begin : g_bad_items
      $error("MAX_ITEMS out of range");
   end
   if (POLL_TRIES < 1 || POLL_GAP < 0) begin : g_bad_poll
      $error("poll parameters out of range");
   end
   if (WBUF_OFS + 4*BUF_WORDS > 2**ADDR_W || RBUF_OFS + 4*RD_WORDS > 2**ADDR_W) begin : g_bad_map
      $error("mailbox offsets exceed address width");
   end

   state_e                          state_q;
   op_e                             op_q;
   logic [CNT_W-1:0]                count_q;
   logic [7:0]                      size_q;
   logic [BUF_WORDS-1:0][31:0]      buf_q;
   logic [IDX_W-1:0]                idx_q;
   res_e                            result_q;

   logic [BUF_BYTES*8-1:0]          pk_bytes;
   logic [7:0]                      pk_size;
   logic                            pk_legal;
   logic                            last_try, gap_done;
   logic                            poll_load, poll_step, cap_en, accept;
   logic                            w_last, r_last, stat_busy, stat_err;

   pwr_seq_pack #(
      .MAX_ITEMS (MAX_ITEMS),
      .BUF_BYTES (BUF_BYTES),
      .CNT_W     (CNT_W)
   ) i_pack (
      .op        (op_e'(req_op)),
      .count     (req_count),
      .addr      (req_addr),
      .data      (req_data),
      .buf_bytes (pk_bytes),
      .size      (pk_size),
      .legal     (pk_legal)
   );

   pwr_seq_poll #(
      .POLL_TRIES (POLL_TRIES),
      .POLL_GAP   (POLL_GAP)
   ) i_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (poll_load),
      .step     (poll_step),
      .last_try (last_try),
      .gap_done (gap_done)
   );

   pwr_seq_rdcap #(
      .MAX_ITEMS (MAX_ITEMS),
      .IDX_W     (IDX_W)
   ) i_rdcap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .cap_en  (cap_en),
      .idx     (idx_q),
      .word    (bus_rdata),
      .rd_data (rd_data)
   );

   assign stat_busy = bus_rdata[BUSY_BIT];
   assign stat_err  = bus_rdata[ERR_BIT];
   assign w_last    = (idx_q == IDX_W'((int'(size_q) + 3) / 4 - 1));
   assign r_last    = (idx_q == IDX_W'((int'(count_q) + 3) / 4 - 1));
   assign accept    = (state_q == ST_IDLE) && req_valid && pk_legal;
   assign poll_load = (state_q == ST_CMD) && bus_ready;
   assign poll_step = (state_q == ST_STAT) && bus_ready && stat_busy && !last_try;
   assign cap_en    = (state_q == ST_RBUF) && bus_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= OP_WR;
         count_q  <= '0;
         size_q   <= 8'd0;
         buf_q    <= '0;
         idx_q    <= '0;
         result_q <= RES_OK;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (pk_legal) begin
                     op_q    <= op_e'(req_op);
                     count_q <= req_count;
                     size_q  <= pk_size;
                     buf_q   <= pk_bytes;
                     idx_q   <= '0;
                     state_q <= ST_WBUF;
                  end else begin
                     result_q <= RES_REJECT;
                     state_q  <= ST_DONE;
                  end
               end
            end
            ST_WBUF: begin
               if (bus_ready) begin
                  if (w_last) begin
                     idx_q   <= '0;
                     state_q <= ST_CMD;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            ST_CMD: begin
               if (bus_ready) state_q <= ST_STAT;
            end
            ST_STAT: begin
               if (bus_ready) begin
                  if (!stat_busy) begin
                     if (stat_err) begin
                        result_q <= RES_IOERR;
                        state_q  <= ST_DONE;
                     end else if (op_q == OP_RD) begin
                        idx_q   <= '0;
                        state_q <= ST_RBUF;
                     end else begin
                        result_q <= RES_OK;
                        state_q  <= ST_DONE;
                     end
                  end else if (last_try) begin
                     result_q <= RES_TIMEOUT;
                     state_q  <= ST_DONE;
                  end else begin
                     state_q <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               if (gap_done) state_q <= ST_STAT;
            end
            ST_RBUF: begin
               if (bus_ready) begin
                  if (r_last) begin
                     result_q <= RES_OK;
                     state_q  <= ST_DONE;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_valid = 1'b0;
      bus_write = 1'b0;
      bus_addr  = '0;
      bus_wdata = 32'h0;
      case (state_q)
         ST_WBUF: begin
            bus_valid = 1'b1;
            bus_write = 1'b1;
            bus_addr  = ADDR_W'(WBUF_OFS + 4*int'(idx_q));
            bus_wdata = buf_q[idx_q];
         end
         ST_CMD: begin
            bus_valid = 1'b1;
            bus_write = 1'b1;
            bus_addr  = ADDR_W'(CMD_OFS);
            bus_wdata = {8'h00, size_q, 2'b00, op_q, 4'b0000, CMD_CODE};
         end
         ST_STAT: begin
            bus_valid = 1'b1;
            bus_addr  = ADDR_W'(STAT_OFS);
         end
         ST_RBUF: begin
            bus_valid = 1'b1;
            bus_addr  = ADDR_W'(RBUF_OFS + 4*int'(idx_q));
         end
         default: ;
      endcase
   end

   assign req_ready = (state_q == ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign result    = result_q;

endmodule

// File: rtl/pwr_reg_seq_chk.sv
module pwr_reg_seq_chk #(
   parameter int MAX_ITEMS  = 5,
   parameter int POLL_TRIES = 100000,
   parameter int POLL_GAP   = 100,
   parameter int ADDR_W     = 8,
   parameter int CMD_OFS    = 'h00,
   parameter int STAT_OFS   = 'h04,
   parameter int CNT_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_op,
   input logic [CNT_W-1:0]  req_count,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_ready,
   input logic              done,
   input logic [1:0]        result
);

   int  polls_q;
   int  since_q;
   logic stat_ack, cmd_ack;

   assign stat_ack = bus_valid && bus_ready && !bus_write && bus_addr == ADDR_W'(STAT_OFS);
   assign cmd_ack  = bus_valid && bus_ready && bus_write && bus_addr == ADDR_W'(CMD_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         polls_q <= 0;
         since_q <= 0;
      end else begin
         if (cmd_ack)       polls_q <= 0;
         else if (stat_ack) polls_q <= polls_q + 1;
         if (stat_ack)                  since_q <= 0;
         else if (since_q < 1000000)    since_q <= since_q + 1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_valid && !done));

   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_reject_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready &&
       (req_count == '0 || int'(req_count) > MAX_ITEMS || req_op == 2'd3))
      |=> (done && result == 2'd1 && !bus_valid));

   assert_cmd_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ack |-> (bus_wdata[7:0] == 8'hFF && bus_wdata[11:8] == 4'h0 &&
                   bus_wdata[31:24] == 8'h00 && bus_wdata[15:12] <= 4'd2));

   assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      polls_q <= POLL_TRIES);

   assert_timeout_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == 2'd2) |-> polls_q == POLL_TRIES);

   assert_poll_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_ack && polls_q != 0) |-> since_q >= POLL_GAP);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

endmodule

bind pwr_reg_seq pwr_reg_seq_chk #(
   .MAX_ITEMS  (MAX_ITEMS),
   .POLL_TRIES (POLL_TRIES),
   .POLL_GAP   (POLL_GAP),
   .ADDR_W     (ADDR_W),
   .CMD_OFS    (CMD_OFS),
   .STAT_OFS   (STAT_OFS),
   .CNT_W      (CNT_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .req_count (req_count),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_ready (bus_ready),
   .done      (done),
   .result    (result)
);

// File: tb/test_pwr_reg_seq.sv
module test_pwr_reg_seq;

   localparam int TRIES = 6;
   localparam int GAP   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [3:0]  req_count = 4'd0;
   logic [79:0] req_addr = '0;
   logic [39:0] req_data = '0;
   logic        bus_valid, bus_write;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_ready = 1'b0;
   logic [31:0] bus_rdata = 32'h0;
   logic        done;
   logic [1:0]  result;
   logic [39:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pwr_reg_seq #(.POLL_TRIES(TRIES), .POLL_GAP(GAP)) i_pwr_reg_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_count(req_count), .req_addr(req_addr), .req_data(req_data),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .done(done), .result(result), .rd_data(rd_data));

   // mailbox model
   logic [31:0] mb_wbuf [0:3];
   logic [31:0] mb_rbuf [0:1];
   logic [31:0] mb_cmd;
   int mb_wwrites, mb_cmds, mb_stats, mb_rreads, mb_any, busy_left, cyc, widx;
   int stat_cyc [0:15];
   bit err_flag, stall_en, phase, order_bad;

   always @(negedge clk) begin
      cyc++;
      if (bus_valid) mb_any++;
      if (bus_valid && (!stall_en || phase)) begin
         bus_ready = 1'b1;
         bus_rdata = 32'h0;
         if (bus_write && bus_addr >= 8'h80 && bus_addr < 8'h90) begin
            widx = (int'(bus_addr) - 'h80) / 4;
            if (widx != mb_wwrites || mb_cmds != 0) order_bad = 1'b1;
            mb_wbuf[widx] = bus_wdata;
            mb_wwrites++;
         end else if (bus_write && bus_addr == 8'h00) begin
            mb_cmd = bus_wdata;
            mb_cmds++;
         end else if (!bus_write && bus_addr == 8'h04) begin
            stat_cyc[mb_stats % 16] = cyc;
            mb_stats++;
            if (mb_cmds == 0) order_bad = 1'b1;
            if (busy_left > 0) begin
               bus_rdata = 32'h1;
               busy_left--;
            end else begin
               bus_rdata = {30'h0, err_flag, 1'b0};
            end
         end else if (!bus_write && bus_addr >= 8'h90 && bus_addr < 8'h98) begin
            bus_rdata = mb_rbuf[(int'(bus_addr) - 'h90) / 4];
            mb_rreads++;
            if (mb_stats == 0) order_bad = 1'b1;
         end else begin
            order_bad = 1'b1;
         end
      end else begin
         bus_ready = 1'b0;
      end
      phase = ~phase;
   end

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] exp_buf(input int op, input int cnt,
                                            input logic [79:0] a, input logic [39:0] d);
      logic [7:0] b [0:15];
      logic [127:0] r;
      for (int j = 0; j < 16; j++) b[j] = 8'h00;
      if (op == 2) begin
         b[0] = a[7:0]; b[1] = a[15:8]; b[2] = d[7:0]; b[3] = d[15:8];
      end else begin
         for (int i = 0; i < cnt; i++) begin
            b[2*i]   = a[16*i +: 8];
            b[2*i+1] = a[16*i+8 +: 8];
            if (op == 0) b[2*cnt+i] = d[8*i +: 8];
         end
      end
      for (int j = 0; j < 16; j++) r[8*j +: 8] = b[j];
      return r;
   endfunction

   function automatic int exp_size(input int op, input int cnt);
      return (op == 2) ? 4 : (op == 1) ? 2*cnt : 3*cnt;
   endfunction

   task automatic run(input int op, input int cnt, input logic [79:0] a, input logic [39:0] d,
                      input int busy, input bit err, input bit stall,
                      output logic [1:0] res, output logic [39:0] rd, output int lat);
      mb_wwrites = 0; mb_cmds = 0; mb_stats = 0; mb_rreads = 0; mb_any = 0;
      order_bad = 1'b0; busy_left = busy; err_flag = err; stall_en = stall;
      mb_cmd = 32'h0;
      for (int k = 0; k < 4; k++) mb_wbuf[k] = 32'h0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); req_count = 4'(cnt); req_addr = a; req_data = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!done && lat < 5000) begin
         @(negedge clk);
         lat++;
      end
      res = result;
      rd  = rd_data;
      chk(done == 1'b1, "R1 done pulse seen", 128'(done), 128'd1);
      @(negedge clk);
      chk(!done && req_ready, "R1 done single cycle then idle", 128'({done, req_ready}), 128'b01);
   endtask

   task automatic check_buf(input string tag, input int op, input int cnt,
                            input logic [79:0] a, input logic [39:0] d);
      logic [127:0] eb;
      int nw;
      eb = exp_buf(op, cnt, a, d);
      nw = (exp_size(op, cnt) + 3) / 4;
      chk(mb_wwrites == nw, {tag, " R4 buffer word count"}, 128'(mb_wwrites), 128'(nw));
      chk(!order_bad, {tag, " R4 word order before command"}, 128'(order_bad), 128'd0);
      for (int k = 0; k < nw; k++)
         chk(mb_wbuf[k] == eb[32*k +: 32], {tag, " R3 buffer word"}, 128'(mb_wbuf[k]), 128'(eb[32*k +: 32]));
      chk(mb_cmds == 1 && mb_cmd == {8'h00, 8'(exp_size(op, cnt)), 4'(op), 4'h0, 8'hFF},
          {tag, " R5 command word"}, 128'(mb_cmd), 128'({8'h00, 8'(exp_size(op, cnt)), 4'(op), 4'h0, 8'hFF}));
   endtask

   task automatic t_reset();
      chk(req_ready && !done && !bus_valid && rd_data == '0, "R1 reset state",
          128'({req_ready, done, bus_valid}), 128'b100);
   endtask

   task automatic t_write(input int cnt, input logic [79:0] a, input logic [39:0] d,
                          input int busy, input bit stall);
      logic [1:0] res; logic [39:0] rd; int lat;
      run(0, cnt, a, d, busy, 1'b0, stall, res, rd, lat);
      chk(res == 2'd0, "R6 write result ok", 128'(res), 128'd0);
      chk(mb_stats == busy + 1, "R6 status reads until idle", 128'(mb_stats), 128'(busy + 1));
      chk(mb_rreads == 0, "R9 no response read on write", 128'(mb_rreads), 128'd0);
      check_buf(stall ? "R10 stalled write" : "write", 0, cnt, a, d);
   endtask

   task automatic t_read(input int cnt, input logic [79:0] a, input logic [31:0] w0,
                         input logic [31:0] w1, input int busy);
      logic [1:0] res; logic [39:0] rd; int lat;
      logic [63:0] rb;
      mb_rbuf[0] = w0; mb_rbuf[1] = w1;
      rb = {w1, w0};
      run(1, cnt, a, 40'h0, busy, 1'b0, 1'b0, res, rd, lat);
      chk(res == 2'd0, "R6 read result ok", 128'(res), 128'd0);
      chk(mb_rreads == (cnt + 3) / 4, "R9 response word count", 128'(mb_rreads), 128'((cnt + 3) / 4));
      for (int i = 0; i < cnt; i++)
         chk(rd[8*i +: 8] == rb[8*i +: 8], "R9 read byte", 128'(rd[8*i +: 8]), 128'(rb[8*i +: 8]));
      check_buf("read", 1, cnt, a, 40'h0);
   endtask

   task automatic t_rmw(input logic [15:0] ad, input logic [7:0] val, input logic [7:0] mask);
      logic [1:0] res; logic [39:0] rd; int lat;
      run(2, 1, {64'h0, ad}, {24'h0, mask, val}, 1, 1'b0, 1'b0, res, rd, lat);
      chk(res == 2'd0, "R6 rmw result ok", 128'(res), 128'd0);
      chk(mb_wbuf[0] == {mask, val, ad}, "R3 rmw word", 128'(mb_wbuf[0]), 128'({mask, val, ad}));
      check_buf("rmw", 2, 1, {64'h0, ad}, {24'h0, mask, val});
   endtask

   task automatic t_reject(input int op, input int cnt);
      logic [1:0] res; logic [39:0] rd; int lat;
      run(op, cnt, 80'h1234, 40'h56, 0, 1'b0, 1'b0, res, rd, lat);
      chk(res == 2'd1, "R2 reject code", 128'(res), 128'd1);
      chk(lat == 1, "R2 reject latency", 128'(lat), 128'd1);
      chk(mb_any == 0, "R2 no bus traffic", 128'(mb_any), 128'd0);
   endtask

   task automatic t_ioerr();
      logic [1:0] res; logic [39:0] rd; int lat;
      run(1, 2, {48'h0, 16'h0102, 16'h0304}, 40'h0, 2, 1'b1, 1'b0, res, rd, lat);
      chk(res == 2'd3, "R7 io error code", 128'(res), 128'd3);
      chk(mb_rreads == 0, "R7 no response read", 128'(mb_rreads), 128'd0);
   endtask

   task automatic t_timeout();
      logic [1:0] res; logic [39:0] rd; int lat; int mingap;
      run(0, 2, {48'h0, 16'h00A0, 16'h00A1}, 40'h7788, 1000, 1'b0, 1'b0, res, rd, lat);
      chk(res == 2'd2, "R8 timeout code", 128'(res), 128'd2);
      chk(mb_stats == TRIES, "R8 status read count", 128'(mb_stats), 128'(TRIES));
      mingap = 1000;
      for (int k = 1; k < mb_stats && k < 16; k++)
         if (stat_cyc[k] - stat_cyc[k-1] < mingap) mingap = stat_cyc[k] - stat_cyc[k-1];
      chk(mingap >= GAP + 1, "R8 poll spacing", 128'(mingap), 128'(GAP + 1));
      busy_left = 0;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write(1, 80'h0000_0000_0000_0000_1A2B, 40'h00000000C3, 0, 1'b0);
      t_write(5, 80'h0105_0104_0103_0102_0101, 40'h5544332211, 3, 1'b1);
      t_read(2, {48'h0, 16'h0220, 16'h0210}, 32'hDDCCBBAA, 32'h0, 1);
      t_read(5, 80'h0305_0304_0303_0302_0301, 32'h44332211, 32'h000000E5, 2);
      t_rmw(16'h0456, 8'hA5, 8'h0F);
      t_reject(0, 0);
      t_reject(1, 6);
      t_reject(3, 2);
      t_ioerr();
      t_timeout();
      t_write(3, 80'h0000_0000_0033_0022_0011, 40'h0000CCBBAA, 0, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule